// File: doc/BRIEF.md
# Three-Way Miss Classifier

The classifier sits beside a small set-associative cache model and sorts each lookup into one of four outcomes. It tracks every block address it has ever seen, and the first use of a block is reported as compulsory. A later miss is checked against a shadow store. That shadow store is fully associative, uses LRU replacement, and holds as many lines as the set-associative model with the same block size. If the shadow store would have hit, the miss is a conflict miss. If the shadow store misses as well, it is a capacity miss. Only one requester is modelled, so no line is ever removed by another agent. The block keeps no data and models no memory latency.

Each strobe on `acc_valid` presents one block address. One cycle later the result shows on `res_valid`, `res_hit` and `res_cat`. Three saturating counters add up the compulsory, conflict and capacity outcomes. A synchronous clear input zeroes all three.

The control sequencer has two states. `ST_IDLE` means no result is being shown. `ST_RESULT` means the result of the previous cycle's access is being shown. Both states go to `ST_RESULT` when `acc_valid` is high and to `ST_IDLE` when it is low. Reset enters `ST_IDLE`.

Top module: `miss_classifier`

## Requirements
- R1: `res_valid` is high in exactly those cycles that follow a cycle with `acc_valid` high. Every access gives exactly one result.
- R2: An access to a block address not referenced since reset reports `res_cat` = 2'b01 (compulsory) with `res_hit` low.
- R3: An access that hits in the set-associative model reports `res_cat` = 2'b00 with `res_hit` high. The set index is the low log2(SETS) address bits, and the tag is the remaining bits.
- R4: An access that misses in the set-associative model, is not a first reference, and would hit in the shadow store of SETS*WAYS lines reports `res_cat` = 2'b10 (conflict).
- R5: An access that misses in both stores and is not a first reference reports `res_cat` = 2'b11 (capacity).
- R6: Both stores use true LRU replacement and are updated on every access. A hit makes its line the most recently used.
- R7: Each counter (`cnt_comp`, `cnt_conf`, `cnt_cap`) increments by exactly one per result of its category. Hits leave all counters unchanged.
- R8: A counter at its all-ones value stays there.
- R9: `clr_cnt` high zeroes all counters at the next clock edge. The clear wins over an increment in the same cycle.
- R10: Reset empties both stores, forgets every referenced address, zeroes the counters and shows no result.
- R11: While `res_valid` is low, `res_cat` is 2'b00 and `res_hit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Block address of the access |
| clr_cnt | input | 1 | Synchronous clear of the three counters |
| res_valid | output | 1 | Result of the previous cycle's access is shown |
| res_hit | output | 1 | Access hit in the set-associative model |
| res_cat | output | 2 | 00 hit, 01 compulsory, 10 conflict, 11 capacity |
| cnt_comp | output | CNT_W | Saturating count of compulsory misses |
| cnt_conf | output | CNT_W | Saturating count of conflict misses |
| cnt_cap | output | CNT_W | Saturating count of capacity misses |

## Verification
The assertions assume that `acc_addr` is a known value whenever `acc_valid` is high. They also assume that `clr_cnt` may arrive in any cycle, including a cycle with an access. The stimulus drives all inputs from the falling edge and gives every address a defined value. It places a clear on the same cycle as a capacity miss on purpose. The access patterns are chosen so that each expected category follows directly from LRU order. One pattern alternates blocks within a single set. Another cycles nine blocks of one set through an eight-line shadow store, so that every later pass misses in both stores.

// File: rtl/miss_cls_pkg.sv
package miss_cls_pkg;

    typedef enum logic [1:0] {
        CAT_HIT  = 2'b00,
        CAT_COMP = 2'b01,
        CAT_CONF = 2'b10,
        CAT_CAP  = 2'b11
    } miss_cat_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESULT
    } cls_state_e;

endpackage

// File: rtl/lru_tag_store.sv
module lru_tag_store #(
    parameter  int SETS  = 4,
    parameter  int WAYS  = 2,
    parameter  int TAG_W = 4,
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int AGE_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_en,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit
);

    localparam logic [AGE_W-1:0] AGE_OLD = AGE_W'(WAYS - 1);

    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [AGE_W-1:0] age_q [SETS][WAYS];
    logic [WAYS-1:0]  vld_q [SETS];

    logic [WAYS-1:0]  hit_vec;
    logic [WAYS-1:0]  old_vec;
    logic [AGE_W-1:0] ref_age;

    always_comb begin
        ref_age = AGE_OLD;
        for (int w = 0; w < WAYS; w++) begin
            hit_vec[w] = vld_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
            old_vec[w] = (age_q[lk_idx][w] == AGE_OLD);
        end
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) ref_age = age_q[lk_idx][w];
        end
        lk_hit = |hit_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w] <= '0;
                    age_q[s][w] <= AGE_W'(w);
                end
            end
        end else if (lk_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (lk_hit ? hit_vec[w] : old_vec[w]) begin
                    age_q[lk_idx][w] <= '0;
                    tag_q[lk_idx][w] <= lk_tag;
                    vld_q[lk_idx][w] <= 1'b1;
                end else if (age_q[lk_idx][w] < ref_age) begin
                    age_q[lk_idx][w] <= age_q[lk_idx][w] + 1'b1;
                end
            end
        end
    end

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R6
    AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(old_vec) == 1); // R6
    AST_REFILL_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_en |=> (lk_idx != $past(lk_idx)) || (lk_tag != $past(lk_tag)) || lk_hit); // R6

endmodule

// File: rtl/first_ref_tracker.sv
module first_ref_tracker #(
    parameter  int ADDR_W = 6,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mark_en,
    input  logic [ADDR_W-1:0] mark_addr,
    output logic              seen
);

    logic [DEPTH-1:0] seen_q;

    assign seen = seen_q[mark_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (mark_en) begin
            seen_q[mark_addr] <= 1'b1;
        end
    end

    AST_SEEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        mark_en |=> seen_q[$past(mark_addr)]); // R2
    AST_NEVER_FORGETS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $countones(seen_q) >= $past($countones(seen_q))); // R2

endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(cnt)); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (cnt == CNT_MAX)) |=> (cnt == CNT_MAX)); // R8
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0)); // R9

endmodule

// File: rtl/miss_classifier.sv
module miss_classifier
    import miss_cls_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int SETS   = 4,
    parameter int WAYS   = 2,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              clr_cnt,
    output logic              res_valid,
    output logic              res_hit,
    output logic [1:0]        res_cat,
    output logic [CNT_W-1:0]  cnt_comp,
    output logic [CNT_W-1:0]  cnt_conf,
    output logic [CNT_W-1:0]  cnt_cap
);

    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam int LINES = SETS * WAYS;

    cls_state_e state_q, state_d;
    miss_cat_e  cat_d, cat_q;
    logic       sa_hit, fa_hit, seen;
    logic [CNT_W-1:0] cnt_arr [3];

    lru_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_sa_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .lk_en  (acc_valid),
        .lk_idx (acc_addr[IDX_W-1:0]),
        .lk_tag (acc_addr[ADDR_W-1:IDX_W]),
        .lk_hit (sa_hit)
    );

    lru_tag_store #(.SETS(1), .WAYS(LINES), .TAG_W(ADDR_W)) u_fa_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .lk_en  (acc_valid),
        .lk_idx (1'b0),
        .lk_tag (acc_addr),
        .lk_hit (fa_hit)
    );

    first_ref_tracker #(.ADDR_W(ADDR_W)) u_first_ref (
        .clk       (clk),
        .rst_n     (rst_n),
        .mark_en   (acc_valid),
        .mark_addr (acc_addr),
        .seen      (seen)
    );

    always_comb begin
        if (!seen)       cat_d = CAT_COMP;
        else if (sa_hit) cat_d = CAT_HIT;
        else if (fa_hit) cat_d = CAT_CONF;
        else             cat_d = CAT_CAP;
    end

    generate
        for (genvar g = 0; g < 3; g++) begin : g_cnt
            sat_counter #(.CNT_W(CNT_W)) u_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (clr_cnt),
                .inc   (acc_valid && (cat_d == miss_cat_e'(g + 1))),
                .cnt   (cnt_arr[g])
            );
        end
    endgenerate

    assign cnt_comp = cnt_arr[0];
    assign cnt_conf = cnt_arr[1];
    assign cnt_cap  = cnt_arr[2];

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = acc_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = acc_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cat_q   <= CAT_HIT;
        end else begin
            state_q <= state_d;
            if (acc_valid) cat_q <= cat_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_RESULT: begin
                res_valid = 1'b1;
                res_cat   = cat_q;
                res_hit   = (cat_q == CAT_HIT);
            end
            default: begin
                res_valid = 1'b0;
                res_cat   = CAT_HIT;
                res_hit   = 1'b0;
            end
        endcase
    end

    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> res_valid); // R1
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !res_valid); // R1
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (res_cat == 2'b00) && !res_hit); // R11
    AST_HIT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_hit == (res_cat == 2'b00))); // R3

endmodule

// File: tb/test_miss_classifier.sv
module test_miss_classifier;

    localparam int ADDR_W = 6;
    localparam int CNT_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              acc_valid = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic              clr_cnt = 1'b0;
    logic              res_valid, res_hit;
    logic [1:0]        res_cat;
    logic [CNT_W-1:0]  cnt_comp, cnt_conf, cnt_cap;

    always #5 clk = ~clk;

    miss_classifier #(.ADDR_W(ADDR_W), .SETS(4), .WAYS(2), .CNT_W(CNT_W)) i_miss_classifier (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .clr_cnt(clr_cnt), .res_valid(res_valid), .res_hit(res_hit), .res_cat(res_cat),
        .cnt_comp(cnt_comp), .cnt_conf(cnt_conf), .cnt_cap(cnt_cap)
    );

    int n_cmp = 0;
    int n_bad = 0;

    logic [1:0]        q_cat [$];
    string             q_req [$];
    logic [ADDR_W-1:0] q_addr [$];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic access(input logic [ADDR_W-1:0] a, input logic [1:0] c,
                          input string req, input bit clr = 1'b0);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_addr  = a;
        clr_cnt   = clr;
        q_addr.push_back(a);
        q_cat.push_back(c);
        q_req.push_back(req);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            acc_valid = 1'b0;
            clr_cnt   = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        acc_valid = 1'b0;
        clr_cnt = 1'b0;
        q_cat.delete();
        q_req.delete();
        q_addr.delete();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Scoreboard monitor: pops one expected item per shown result
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (res_valid) begin
                    if (q_cat.size() == 0) begin
                        chk("R1 spurious result", 32'(res_valid), 32'd0);
                    end else begin
                        logic [1:0] ec;
                        string      rq;
                        ec = q_cat.pop_front();
                        rq = q_req.pop_front();
                        void'(q_addr.pop_front());
                        chk(rq, 32'(res_cat), 32'(ec));
                        chk("R3 hit flag", 32'(res_hit), 32'(ec == 2'b00));
                    end
                end else begin
                    chk("R11 idle category", 32'(res_cat), 32'd0);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        do_reset();
        chk("R10 res_valid", 32'(res_valid), 32'd0);
        chk("R10 cnt_comp", 32'(cnt_comp), 32'd0);
        chk("R10 cnt_cap", 32'(cnt_cap), 32'd0);

        // set 0 only: blocks 0, 4, 8 (index = addr[1:0])
        access(6'd0, 2'b01, "R2 first 0");
        access(6'd0, 2'b00, "R3 repeat 0");
        access(6'd4, 2'b01, "R2 first 4");
        access(6'd0, 2'b00, "R6 0 refreshed");
        access(6'd8, 2'b01, "R2 first 8");        // evicts 4 (LRU)
        access(6'd0, 2'b00, "R6 0 kept over 4");
        access(6'd4, 2'b10, "R4 conflict 4");     // evicts 8
        access(6'd8, 2'b10, "R4 conflict 8");     // evicts 0
        access(6'd0, 2'b10, "R4 conflict 0");
        idle(3);
        chk("R1 all results seen", 32'(q_cat.size()), 32'd0);
        chk("R7 cnt_comp", 32'(cnt_comp), 32'd3);
        chk("R7 cnt_conf", 32'(cnt_conf), 32'd3);
        chk("R7 cnt_cap", 32'(cnt_cap), 32'd0);

        do_reset();
        chk("R10 cnt_conf after reset", 32'(cnt_conf), 32'd0);
        // nine blocks of set 0 cycled through eight shadow lines
        for (int i = 0; i < 309; i++) begin
            if (i == 0)
                access(6'd0, 2'b01, "R10 tracker cleared");
            else if (i < 9)
                access(6'((i % 9) * 4), 2'b01, "R2 first pass");
            else
                access(6'((i % 9) * 4), 2'b11, "R5 capacity");
        end
        idle(3);
        chk("R8 cnt_cap saturated", 32'(cnt_cap), 32'd255);
        chk("R7 cnt_comp nine", 32'(cnt_comp), 32'd9);
        chk("R7 cnt_conf none", 32'(cnt_conf), 32'd0);

        access(6'd12, 2'b11, "R9 capacity with clear", 1'b1);
        idle(2);
        chk("R9 cnt_cap cleared", 32'(cnt_cap), 32'd0);
        chk("R9 cnt_comp cleared", 32'(cnt_comp), 32'd0);
        access(6'd16, 2'b11, "R9 capacity after clear");
        idle(3);
        chk("R9 count resumes", 32'(cnt_cap), 32'd1);
        chk("R1 queue drained", 32'(q_cat.size()), 32'd0);

        summary();
        $finish;
    end

endmodule